// File: doc/BRIEF.md
# Interrupt Priority Acknowledge Unit

This block keeps the eight-bit processor status word and decides, cycle by cycle, whether a pending maskable interrupt may be taken. The word carries a global interrupt enable bit and a two-bit in-service level field. A maskable request offers a two-bit level, where level 0 is the most urgent. It is taken only when the enable bit is set and the level does not exceed the in-service field. When a request is taken, the block pulses an acknowledge and presents the word as it stood before the acknowledge, ready to be pushed onto the stack. It then clears the enable bit and narrows the in-service field to the taken level minus one. This means that only strictly more urgent levels can nest later.

A software break request is always taken and treated the same way, except that the level field is kept. Software can write the whole word, and it can set or clear the enable bit with dedicated commands. A restore strobe reloads the word from stack data on a return from interrupt, a return from break or a pop of the status word. The arithmetic flags in the word are never computed here; they change only through the write and restore paths.

Top module: `iack_unit`

## Requirements
- R1: After reset the status word is 8'h06 (enable bit 7 low, level field in bits 2:1 equal to 2'b11), the acknowledge is low and the saved-word output is 8'h00.
- R2: An enable command sets bit 7 and a disable command clears it, both one cycle later; when both arrive together, bit 7 is cleared.
- R3: A maskable request of level L is taken only when bit 7 is 1 and L is at most the level field (bits 2:1). A taken request raises the acknowledge in the next cycle for that cycle only.
- R4: In the cycle the acknowledge is high, the saved-word output holds the status word from the cycle of the request, and bit 7 of the status word is 0. The saved-word output keeps its value until the next acknowledge.
- R5: Taking a maskable request of level L other than 0 loads the level field with L-1; taking a level-0 request leaves the level field unchanged.
- R6: A break request, when no restore is present, is always taken: the acknowledge pulses, the old word is saved, bit 7 clears, and the level field is kept. A maskable request in the same cycle is not taken.
- R7: With no restore, request or break taken, a write loads all eight bits of the status word one cycle later.
- R8: A restore loads the supplied stack byte into the status word one cycle later. It wins over the write, the enable commands, break and maskable requests, and no acknowledge follows it.
- R9: When a taken request and a write fall in the same cycle, the write is dropped and the acknowledge update is applied to the old word.
- R10: A maskable request that is not taken leaves the acknowledge low, the status word unchanged and the saved-word output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_vld | input | 1 | Maskable request pending |
| req_lvl | input | 2 | Level of the pending request, 0 most urgent |
| brk_req | input | 1 | Software break request |
| ien_set | input | 1 | Enable command |
| ien_clr | input | 1 | Disable command |
| wr_en | input | 1 | Full-byte write of the status word |
| wr_data | input | 8 | Write data |
| rest_en | input | 1 | Restore strobe from stack |
| rest_data | input | 8 | Stack byte to restore |
| ack_o | output | 1 | Acknowledge pulse |
| save_o | output | 8 | Status word to push on the stack |
| stat_o | output | 8 | Current status word |

## Verification
The collisions that matter are a taken request arriving with a write, a break arriving with a maskable request, and a restore arriving with a request and a write. Each collision is provoked by driving all the contending inputs in one vector of the stimulus table. The result is judged one cycle later from three things: the status word, the acknowledge and the saved word. The bench checks that the winning update was applied to the old word and that the losing input left no trace.

// File: rtl/iack_pkg.sv
package iack_pkg;
   typedef enum logic [2:0] {
      UPD_HOLD    = 3'd0,
      UPD_RESTORE = 3'd1,
      UPD_TAKE    = 3'd2,
      UPD_BREAK   = 3'd3,
      UPD_WRITE   = 3'd4,
      UPD_ENABLE  = 3'd5
   } upd_e;
endpackage

// File: rtl/iack_gate.sv
module iack_gate #(
   parameter int LVL_W = 2
) (
   input  logic             ien,
   input  logic [LVL_W-1:0] isp,
   input  logic             req_vld,
   input  logic [LVL_W-1:0] req_lvl,
   input  logic             brk_req,
   input  logic             rest_en,
   output logic             take_irq,
   output logic             take_brk
);
   localparam int NLVL = 1 << LVL_W;

   logic [NLVL-1:0] admit;

   generate
      for (genvar k = 0; k < NLVL; k++) begin : g_admit
         assign admit[k] = (LVL_W'(k) <= isp);
      end
   endgenerate

   assign take_brk = brk_req & ~rest_en;
   assign take_irq = req_vld & ien & admit[req_lvl] & ~rest_en & ~brk_req;
endmodule

// File: rtl/iack_sel.sv
module iack_sel
   import iack_pkg::*;
(
   input  logic rest_en,
   input  logic take_brk,
   input  logic take_irq,
   input  logic wr_en,
   input  logic ien_set,
   input  logic ien_clr,
   output upd_e upd
);
   always_comb begin
      if (rest_en)                upd = UPD_RESTORE;
      else if (take_brk)          upd = UPD_BREAK;
      else if (take_irq)          upd = UPD_TAKE;
      else if (wr_en)             upd = UPD_WRITE;
      else if (ien_set | ien_clr) upd = UPD_ENABLE;
      else                        upd = UPD_HOLD;
   end
endmodule

// File: rtl/iack_word.sv
module iack_word
   import iack_pkg::*;
#(
   parameter int          W       = 8,
   parameter int          IEN_POS = 7,
   parameter int          ISP_LO  = 1,
   parameter int          LVL_W   = 2,
   parameter logic [W-1:0] RST_VAL = 8'h06
) (
   input  logic             clk,
   input  logic             rst_n,
   input  upd_e             upd,
   input  logic [LVL_W-1:0] req_lvl,
   input  logic             ien_clr,
   input  logic [W-1:0]     wr_data,
   input  logic [W-1:0]     rest_data,
   output logic [W-1:0]     stat
);
   logic [W-1:0] nxt;

   always_comb begin
      nxt = stat;
      unique case (upd)
         UPD_RESTORE: nxt = rest_data;
         UPD_BREAK:   nxt[IEN_POS] = 1'b0;
         UPD_TAKE: begin
            nxt[IEN_POS] = 1'b0;
            if (req_lvl != '0) nxt[ISP_LO +: LVL_W] = req_lvl - 1'b1;
         end
         UPD_WRITE:   nxt = wr_data;
         UPD_ENABLE:  nxt[IEN_POS] = ~ien_clr;
         default:     nxt = stat;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) stat <= RST_VAL;
      else        stat <= nxt;
   end
endmodule

// File: rtl/iack_out.sv
module iack_out #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         taken,
   input  logic [W-1:0] stat,
   output logic         ack,
   output logic [W-1:0] save
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ack  <= 1'b0;
         save <= '0;
      end else begin
         ack <= taken;
         if (taken) save <= stat;
      end
   end
endmodule

// File: rtl/iack_unit.sv
module iack_unit
   import iack_pkg::*;
#(
   parameter int          W       = 8,
   parameter int          IEN_POS = 7,
   parameter int          ISP_LO  = 1,
   parameter int          LVL_W   = 2,
   parameter logic [W-1:0] RST_VAL = 8'h06
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_vld,
   input  logic [LVL_W-1:0] req_lvl,
   input  logic             brk_req,
   input  logic             ien_set,
   input  logic             ien_clr,
   input  logic             wr_en,
   input  logic [W-1:0]     wr_data,
   input  logic             rest_en,
   input  logic [W-1:0]     rest_data,
   output logic             ack_o,
   output logic [W-1:0]     save_o,
   output logic [W-1:0]     stat_o
);
   localparam int ISP_HI = ISP_LO + LVL_W - 1;

   generate
      if (IEN_POS >= W || ISP_HI >= W) begin : g_bad_pos
         $error("iack_unit: field position beyond word width");
      end
      if (IEN_POS >= ISP_LO && IEN_POS <= ISP_HI) begin : g_overlap
         $error("iack_unit: enable bit overlaps level field");
      end
      if (LVL_W < 1 || LVL_W > 4) begin : g_bad_lvl
         $error("iack_unit: level width out of range");
      end
   endgenerate

   logic take_irq, take_brk;
   upd_e upd;

   iack_gate #(.LVL_W(LVL_W)) u_gate (
      .ien      (stat_o[IEN_POS]),
      .isp      (stat_o[ISP_LO +: LVL_W]),
      .req_vld  (req_vld),
      .req_lvl  (req_lvl),
      .brk_req  (brk_req),
      .rest_en  (rest_en),
      .take_irq (take_irq),
      .take_brk (take_brk)
   );

   iack_sel u_sel (
      .rest_en  (rest_en),
      .take_brk (take_brk),
      .take_irq (take_irq),
      .wr_en    (wr_en),
      .ien_set  (ien_set),
      .ien_clr  (ien_clr),
      .upd      (upd)
   );

   iack_word #(
      .W(W), .IEN_POS(IEN_POS), .ISP_LO(ISP_LO), .LVL_W(LVL_W), .RST_VAL(RST_VAL)
   ) u_word (
      .clk       (clk),
      .rst_n     (rst_n),
      .upd       (upd),
      .req_lvl   (req_lvl),
      .ien_clr   (ien_clr),
      .wr_data   (wr_data),
      .rest_data (rest_data),
      .stat      (stat_o)
   );

   iack_out #(.W(W)) u_out (
      .clk   (clk),
      .rst_n (rst_n),
      .taken (take_irq | take_brk),
      .stat  (stat_o),
      .ack   (ack_o),
      .save  (save_o)
   );
endmodule

// File: rtl/iack_unit_chk.sv
module iack_unit_chk #(
   parameter int W       = 8,
   parameter int IEN_POS = 7,
   parameter int ISP_LO  = 1,
   parameter int LVL_W   = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_vld,
   input logic [LVL_W-1:0] req_lvl,
   input logic             brk_req,
   input logic             rest_en,
   input logic [W-1:0]     rest_data,
   input logic             ack_o,
   input logic [W-1:0]     save_o,
   input logic [W-1:0]     stat_o
);
   AST_BLOCKED_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      (req_vld && !brk_req && !rest_en && !stat_o[IEN_POS]) |=> !ack_o); // R3

   AST_SAVE_OLD_WORD: assert property (@(posedge clk) disable iff (!rst_n)
      ack_o |-> (save_o == $past(stat_o) && !stat_o[IEN_POS])); // R4

   AST_LEVEL_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
      (req_vld && !brk_req && !rest_en && stat_o[IEN_POS] && req_lvl != '0
       && req_lvl <= stat_o[ISP_LO +: LVL_W])
      |=> (ack_o && stat_o[ISP_LO +: LVL_W] == LVL_W'($past(req_lvl) - 1'b1))); // R5

   AST_BREAK_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
      (brk_req && !rest_en)
      |=> (ack_o && stat_o[ISP_LO +: LVL_W] == $past(stat_o[ISP_LO +: LVL_W]))); // R6

   AST_RESTORE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      rest_en |=> (stat_o == $past(rest_data) && !ack_o)); // R8
endmodule

bind iack_unit iack_unit_chk #(
   .W(W), .IEN_POS(IEN_POS), .ISP_LO(ISP_LO), .LVL_W(LVL_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_vld   (req_vld),
   .req_lvl   (req_lvl),
   .brk_req   (brk_req),
   .rest_en   (rest_en),
   .rest_data (rest_data),
   .ack_o     (ack_o),
   .save_o    (save_o),
   .stat_o    (stat_o)
);

// File: tb/iack_unit_test.sv
module iack_unit_test;
   typedef struct packed {
      logic       vld;
      logic [1:0] lvl;
      logic       brk;
      logic       set;
      logic       clr;
      logic       wr;
      logic [7:0] wd;
      logic       rs;
      logic [7:0] rd;
      logic       eack;
      logic [7:0] estat;
      logic [7:0] esave;
   } vec_t;

   localparam int NV = 19;
   localparam vec_t VECS [NV] = '{
      // vld lvl  brk  set  clr  wr   wd     rs   rd     ack  stat   save
      '{1'b0,2'd0,1'b0,1'b0,1'b0,1'b0,8'h00,1'b0,8'h00,1'b0,8'h06,8'h00}, // 0 idle R10
      '{1'b1,2'd0,1'b0,1'b0,1'b0,1'b0,8'h00,1'b0,8'h00,1'b0,8'h06,8'h00}, // 1 IE low R3
      '{1'b0,2'd0,1'b0,1'b1,1'b0,1'b0,8'h00,1'b0,8'h00,1'b0,8'h86,8'h00}, // 2 set R2
      '{1'b1,2'd3,1'b0,1'b0,1'b0,1'b0,8'h00,1'b0,8'h00,1'b1,8'h04,8'h86}, // 3 lvl3 R5
      '{1'b0,2'd0,1'b0,1'b1,1'b0,1'b0,8'h00,1'b0,8'h00,1'b0,8'h84,8'h86}, // 4 set R2
      '{1'b1,2'd3,1'b0,1'b0,1'b0,1'b0,8'h00,1'b0,8'h00,1'b0,8'h84,8'h86}, // 5 too low R10
      '{1'b1,2'd2,1'b0,1'b0,1'b0,1'b0,8'h00,1'b0,8'h00,1'b1,8'h02,8'h84}, // 6 lvl2 R4
      '{1'b0,2'd0,1'b0,1'b1,1'b1,1'b0,8'h00,1'b0,8'h00,1'b0,8'h02,8'h84}, // 7 set+clr R2
      '{1'b0,2'd0,1'b0,1'b1,1'b0,1'b0,8'h00,1'b0,8'h00,1'b0,8'h82,8'h84}, // 8 set
      '{1'b1,2'd0,1'b0,1'b0,1'b0,1'b0,8'h00,1'b0,8'h00,1'b1,8'h02,8'h82}, // 9 lvl0 R5
      '{1'b0,2'd0,1'b0,1'b0,1'b0,1'b1,8'hFF,1'b0,8'h00,1'b0,8'hFF,8'h82}, // 10 write R7
      '{1'b1,2'd1,1'b0,1'b0,1'b0,1'b1,8'h00,1'b0,8'h00,1'b1,8'h79,8'hFF}, // 11 take+write R9
      '{1'b0,2'd0,1'b1,1'b0,1'b0,1'b0,8'h00,1'b0,8'h00,1'b1,8'h79,8'h79}, // 12 break R6
      '{1'b1,2'd0,1'b1,1'b1,1'b0,1'b1,8'h11,1'b1,8'hC3,1'b0,8'hC3,8'h79}, // 13 restore R8
      '{1'b1,2'd0,1'b1,1'b0,1'b0,1'b0,8'h00,1'b0,8'h00,1'b1,8'h43,8'hC3}, // 14 brk+irq R6
      '{1'b0,2'd0,1'b0,1'b0,1'b0,1'b0,8'h00,1'b0,8'h00,1'b0,8'h43,8'hC3}, // 15 pulse R3
      '{1'b0,2'd0,1'b0,1'b0,1'b0,1'b1,8'h86,1'b0,8'h00,1'b0,8'h86,8'hC3}, // 16 write R7
      '{1'b0,2'd0,1'b0,1'b0,1'b1,1'b0,8'h00,1'b0,8'h00,1'b0,8'h06,8'hC3}, // 17 clr R2
      '{1'b1,2'd3,1'b0,1'b0,1'b0,1'b0,8'h00,1'b0,8'h00,1'b0,8'h06,8'hC3}  // 18 IE low R10
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req_vld = 1'b0;
   logic [1:0] req_lvl = 2'd0;
   logic       brk_req = 1'b0;
   logic       ien_set = 1'b0;
   logic       ien_clr = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic       rest_en = 1'b0;
   logic [7:0] rest_data = 8'h00;
   logic       ack_o;
   logic [7:0] save_o;
   logic [7:0] stat_o;

   int n_chk = 0;
   int n_bad = 0;
   int cyc = 0;

   always #10 clk = ~clk;

   iack_unit uut (
      .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_lvl(req_lvl),
      .brk_req(brk_req), .ien_set(ien_set), .ien_clr(ien_clr),
      .wr_en(wr_en), .wr_data(wr_data), .rest_en(rest_en),
      .rest_data(rest_data), .ack_o(ack_o), .save_o(save_o), .stat_o(stat_o)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 5000) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: run hung, actual %0d cycles expected < 5000", cyc);
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
      end
   endtask

   task automatic idle_inputs();
      req_vld = 1'b0; req_lvl = 2'd0; brk_req = 1'b0;
      ien_set = 1'b0; ien_clr = 1'b0; wr_en = 1'b0; wr_data = 8'h00;
      rest_en = 1'b0; rest_data = 8'h00;
   endtask

   initial begin
      idle_inputs();
      repeat (3) @(posedge clk);
      #1;
      check8("R1 reset stat", stat_o, 8'h06);
      check8("R1 reset ack", {7'd0, ack_o}, 8'h00);
      check8("R1 reset save", save_o, 8'h00);
      @(negedge clk);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         req_vld = VECS[i].vld; req_lvl = VECS[i].lvl; brk_req = VECS[i].brk;
         ien_set = VECS[i].set; ien_clr = VECS[i].clr;
         wr_en = VECS[i].wr; wr_data = VECS[i].wd;
         rest_en = VECS[i].rs; rest_data = VECS[i].rd;
         @(posedge clk);
         #1;
         check8($sformatf("R3 vec%0d ack", i), {7'd0, ack_o}, {7'd0, VECS[i].eack});
         check8($sformatf("R4 vec%0d stat", i), stat_o, VECS[i].estat);
         check8($sformatf("R4 vec%0d save", i), save_o, VECS[i].esave);
      end

      // R1: reset during operation returns to the initial state
      @(negedge clk);
      idle_inputs();
      wr_en = 1'b1; wr_data = 8'hA5;
      @(negedge clk);
      idle_inputs();
      req_vld = 1'b1; req_lvl = 2'd0;
      @(negedge clk);
      idle_inputs();
      rst_n = 1'b0;
      @(posedge clk);
      #1;
      check8("R1 mid reset stat", stat_o, 8'h06);
      check8("R1 mid reset ack", {7'd0, ack_o}, 8'h00);
      check8("R1 mid reset save", save_o, 8'h00);
      @(negedge clk);
      rst_n = 1'b1;

      // R3: equal level at the boundary is admitted, pulse lasts one cycle
      @(negedge clk);
      wr_en = 1'b1; wr_data = 8'h82;
      @(negedge clk);
      idle_inputs();
      req_vld = 1'b1; req_lvl = 2'd1;
      @(posedge clk);
      #1;
      check8("R3 equal level ack", {7'd0, ack_o}, 8'h01);
      check8("R5 equal level stat", stat_o, 8'h00);
      @(negedge clk);
      @(posedge clk);
      #1;
      check8("R3 pulse drops", {7'd0, ack_o}, 8'h00);

      @(negedge clk);
      idle_inputs();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule